// File: doc/BRIEF.md
# 80-Column Text Blink Attribute Controller

This block decides, character by character, whether an 80-column text cell is drawn in its normal colour pair or in an alternate colour pair. The blink attributes are packed one bit per character in a table in video memory. For each character position presented on `col` and `row`, the block issues a byte address into that table. One cycle later it receives the byte from a synchronous video memory and picks out the character's bit.

A phase timer counts frame pulses and alternates between a normal phase and an alternate phase. The length of each phase is set independently by the two nibbles of a period register, in units of ten frames. A character whose attribute bit is set is drawn with the alternate colour pair while the timer is in the alternate phase. Every other character, and any position outside the active text area, uses the normal pair.

The block is driven once per character slot by the text fetch sequencer. It returns palette indices that the pixel stage uses for the character's set and clear pixels.

Top module: `text_blink_ctrl`

## Requirements
- R1: The upper address bits are a table base: `tbl_page[2:0]` drives `rd_addr[16:14]`, `tbl_blk[4:0]` drives `rd_addr[13:9]`, and the base has zeros in bits 8..0.
- R2: `rd_addr[8:0]` equals floor((row*80 + col)/8). `rd_addr` is registered and is due one clock edge after `col`/`row` are sampled.
- R3: Within the returned byte, the character with linear index L uses bit 7 - (L mod 8), so the leftmost character of a group of eight sits in the most significant bit.
- R4: Colour pairs split into nibbles. `norm_clr[7:4]` and `norm_clr[3:0]` are the normal foreground and background. `alt_clr[7:4]` and `alt_clr[3:0]` are the alternate foreground and background. The alternate pair is output only when the attribute bit is 1 and the timer is in the alternate phase; otherwise the normal pair is output. `fg_idx`/`bg_idx` are due three clock edges after `col`/`row` are sampled, with memory data returned one edge after `rd_addr`.
- R5: After reset the timer is in the normal phase. It stays there for `period[7:4]`×10 frame pulses, then in the alternate phase for `period[3:0]`×10 pulses, and repeats. The phase changes only on a frame pulse.
- R6: If `period[3:0]` is 0, the alternate phase never occurs. If `period[7:4]` is 0 and `period[3:0]` is non-zero, the normal phase ends at the first ten-frame boundary and the alternate phase then holds.
- R7: When `period` is 0x00, the timer returns to the normal phase within one clock, with or without frame pulses.
- R8: `tall_rows` = 0 gives 24 active rows and 1 gives 27. A position with row at or beyond the active count, or with col of 80 or more, is always drawn in the normal pair.
- R9: Synchronous active-high reset clears `rd_addr`, `fg_idx` and `bg_idx` to 0 and places the timer at the start of the normal phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col | input | 7 | Character column, 0..79 active |
| row | input | 5 | Character row |
| frame_tick | input | 1 | One-cycle pulse per frame |
| tbl_page | input | 3 | Table base bits 16..14 |
| tbl_blk | input | 5 | Table base bits 13..9 |
| norm_clr | input | 8 | Normal foreground (high nibble) / background (low nibble) |
| alt_clr | input | 8 | Alternate foreground / background |
| period | input | 8 | Normal-phase units (high nibble), alternate-phase units (low nibble) |
| tall_rows | input | 1 | 0: 24 rows, 1: 27 rows |
| rd_addr | output | 17 | Attribute byte address |
| rd_data | input | 8 | Attribute byte, one cycle after rd_addr |
| fg_idx | output | 4 | Selected foreground palette index |
| bg_idx | output | 4 | Selected background palette index |

## Verification
A new position enters every cycle. The address for a position is due after one edge and its colours after three: one for the address register, one for the memory, and one for the colour register. The bench keeps a three-deep history of the positions it has driven. At each falling edge it compares `rd_addr` against the entry from one slot back and the colour outputs against the entry from three slots back. Phase changes appear at the colour outputs one edge after the frame pulse is taken, so the bench holds a position steady and samples four cycles after each pulse.

// File: rtl/text_blink_pkg.sv
package text_blink_pkg;
  localparam int ADDR_W   = 17;
  localparam int PAGE_W   = 3;
  localparam int BLK_W    = 5;
  localparam int IDX_W    = ADDR_W - PAGE_W - BLK_W;
  localparam int CLR_W    = 4;

  typedef enum logic {
    PH_NORMAL = 1'b0,
    PH_ALT    = 1'b1
  } blink_phase_e;

  typedef struct packed {
    logic [CLR_W-1:0] fg;
    logic [CLR_W-1:0] bg;
  } clr_pair_t;
endpackage

// File: rtl/blink_addr_gen.sv
module blink_addr_gen
  import text_blink_pkg::*;
#(
  parameter int COLS       = 80,
  parameter int COL_W      = 7,
  parameter int ROW_W      = 5,
  parameter int ROWS_SHORT = 24,
  parameter int ROWS_LONG  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic              tall_rows,
  input  logic [PAGE_W-1:0] tbl_page,
  input  logic [BLK_W-1:0]  tbl_blk,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        bit_pos,
  output logic              in_range
);
  localparam int LIN_W = $clog2((2**ROW_W) * COLS + 2**COL_W);

  logic [LIN_W-1:0] lin;
  logic [ROW_W-1:0] row_lim;
  logic             in_range_c;

  always_comb begin
    lin        = LIN_W'(row) * LIN_W'(COLS) + LIN_W'(col);
    row_lim    = tall_rows ? ROW_W'(ROWS_LONG) : ROW_W'(ROWS_SHORT);
    in_range_c = (col < COL_W'(COLS)) && (row < row_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr  <= '0;
      bit_pos  <= '0;
      in_range <= 1'b0;
    end else begin
      rd_addr  <= {tbl_page, tbl_blk, IDX_W'(lin >> 3)};
      bit_pos  <= lin[2:0];
      in_range <= in_range_c;
    end
  end

  // R1
  base_field_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_addr[ADDR_W-1:IDX_W] == {$past(tbl_page), $past(tbl_blk)});

  // R2
  first_group_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(row) == '0 && $past(col) < COL_W'(8)) |-> rd_addr[IDX_W-1:0] == '0);
endmodule

// File: rtl/blink_phase_timer.sv
module blink_phase_timer
  import text_blink_pkg::*;
#(
  parameter int FRAMES_PER_UNIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_tick,
  input  logic [7:0]   period,
  output blink_phase_e phase
);
  localparam int PRE_W = (FRAMES_PER_UNIT > 1) ? $clog2(FRAMES_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(FRAMES_PER_UNIT - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [3:0]       unit_cnt;
  logic [3:0]       on_len, off_len, cur_len, oth_len;
  logic             both_zero, unit_tick, span_done;

  always_comb begin
    on_len    = period[7:4];
    off_len   = period[3:0];
    both_zero = (on_len == 4'd0) && (off_len == 4'd0);
    cur_len   = (phase == PH_NORMAL) ? on_len  : off_len;
    oth_len   = (phase == PH_NORMAL) ? off_len : on_len;
    unit_tick = frame_tick && (pre_cnt == PRE_LAST);
    span_done = ({1'b0, unit_cnt} + 5'd1) >= {1'b0, cur_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_NORMAL;
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else begin
      if (frame_tick) begin
        pre_cnt <= unit_tick ? '0 : pre_cnt + 1'b1;
      end
      if (both_zero) begin
        phase    <= PH_NORMAL;
        unit_cnt <= '0;
      end else if (unit_tick) begin
        if (span_done) begin
          unit_cnt <= '0;
          if (oth_len != 4'd0) begin
            phase <= (phase == PH_NORMAL) ? PH_ALT : PH_NORMAL;
          end
        end else begin
          unit_cnt <= unit_cnt + 4'd1;
        end
      end
    end
  end

  // R5
  prescale_range_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_LAST);

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(frame_tick) && $past(period) != 8'h00) |-> $stable(phase));

  // R7
  both_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(period) == 8'h00) |-> phase == PH_NORMAL);
endmodule

// File: rtl/blink_color_sel.sv
module blink_color_sel
  import text_blink_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rd_data,
  input  logic [2:0]       bit_pos,
  input  logic             in_range,
  input  blink_phase_e     phase,
  input  logic [7:0]       norm_clr,
  input  logic [7:0]       alt_clr,
  output logic [CLR_W-1:0] fg_idx,
  output logic [CLR_W-1:0] bg_idx
);
  logic      attr_bit, pick_alt;
  clr_pair_t norm_pair, alt_pair, sel_pair;

  always_comb begin
    attr_bit  = rd_data[3'd7 - bit_pos];
    pick_alt  = in_range && attr_bit && (phase == PH_ALT);
    norm_pair = clr_pair_t'(norm_clr);
    alt_pair  = clr_pair_t'(alt_clr);
    sel_pair  = pick_alt ? alt_pair : norm_pair;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_idx <= '0;
      bg_idx <= '0;
    end else begin
      fg_idx <= sel_pair.fg;
      bg_idx <= sel_pair.bg;
    end
  end

  // R4
  normal_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase) == PH_NORMAL) |->
      (fg_idx == $past(norm_clr[7:4]) && bg_idx == $past(norm_clr[3:0])));

  // R8
  outside_area_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_range)) |->
      (fg_idx == $past(norm_clr[7:4]) && bg_idx == $past(norm_clr[3:0])));

  // R9
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fg_idx == '0 && bg_idx == '0));
endmodule

// File: rtl/text_blink_ctrl.sv
module text_blink_ctrl
  import text_blink_pkg::*;
#(
  parameter int COLS            = 80,
  parameter int COL_W           = 7,
  parameter int ROW_W           = 5,
  parameter int ROWS_SHORT      = 24,
  parameter int ROWS_LONG       = 27,
  parameter int FRAMES_PER_UNIT = 10,
  parameter int RD_LATENCY      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic              frame_tick,
  input  logic [PAGE_W-1:0] tbl_page,
  input  logic [BLK_W-1:0]  tbl_blk,
  input  logic [7:0]        norm_clr,
  input  logic [7:0]        alt_clr,
  input  logic [7:0]        period,
  input  logic              tall_rows,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [CLR_W-1:0]  fg_idx,
  output logic [CLR_W-1:0]  bg_idx
);
  logic [2:0]   pos_s0;
  logic         rng_s0;
  blink_phase_e phase;

  logic [2:0] pos_pipe [RD_LATENCY+1];
  logic       rng_pipe [RD_LATENCY+1];

  blink_addr_gen #(
    .COLS(COLS), .COL_W(COL_W), .ROW_W(ROW_W),
    .ROWS_SHORT(ROWS_SHORT), .ROWS_LONG(ROWS_LONG)
  ) u_addr (
    .clk(clk), .rst(rst), .col(col), .row(row), .tall_rows(tall_rows),
    .tbl_page(tbl_page), .tbl_blk(tbl_blk),
    .rd_addr(rd_addr), .bit_pos(pos_s0), .in_range(rng_s0)
  );

  assign pos_pipe[0] = pos_s0;
  assign rng_pipe[0] = rng_s0;

  for (genvar s = 0; s < RD_LATENCY; s++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        pos_pipe[s+1] <= '0;
        rng_pipe[s+1] <= 1'b0;
      end else begin
        pos_pipe[s+1] <= pos_pipe[s];
        rng_pipe[s+1] <= rng_pipe[s];
      end
    end
  end

  blink_phase_timer #(.FRAMES_PER_UNIT(FRAMES_PER_UNIT)) u_timer (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .period(period), .phase(phase)
  );

  blink_color_sel u_sel (
    .clk(clk), .rst(rst), .rd_data(rd_data),
    .bit_pos(pos_pipe[RD_LATENCY]), .in_range(rng_pipe[RD_LATENCY]),
    .phase(phase), .norm_clr(norm_clr), .alt_clr(alt_clr),
    .fg_idx(fg_idx), .bg_idx(bg_idx)
  );
endmodule

// File: tb/text_blink_ctrl_tb.sv
module text_blink_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  col = '0;
  logic [4:0]  row = '0;
  logic        frame_tick = 1'b0;
  logic [2:0]  tbl_page = '0;
  logic [4:0]  tbl_blk = '0;
  logic [7:0]  norm_clr = 8'h00;
  logic [7:0]  alt_clr = 8'h00;
  logic [7:0]  period = 8'h00;
  logic        tall_rows = 1'b0;
  logic [16:0] rd_addr;
  logic [7:0]  rd_data;
  logic [3:0]  fg_idx, bg_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  text_blink_ctrl u_dut (
    .clk(clk), .rst(rst), .col(col), .row(row), .frame_tick(frame_tick),
    .tbl_page(tbl_page), .tbl_blk(tbl_blk), .norm_clr(norm_clr), .alt_clr(alt_clr),
    .period(period), .tall_rows(tall_rows), .rd_addr(rd_addr), .rd_data(rd_data),
    .fg_idx(fg_idx), .bg_idx(bg_idx)
  );

  function automatic logic [7:0] mem_byte(input logic [16:0] a);
    return a[7:0] ^ a[16:9] ^ (a[8:1] * 8'd29);
  endfunction

  always_ff @(posedge clk) rd_data <= mem_byte(rd_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_addr(input int c, input int r);
    int lin = r * 80 + c;
    return {tbl_page, tbl_blk, 9'(lin / 8)};
  endfunction

  function automatic bit exp_alt_phase(input int f, input int on, input int off);
    int u = f / 10;
    if (off == 0) return 1'b0;
    if (on == 0) return u >= 1;
    return (u % (on + off)) >= on;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic sweep(input bit alt_now);
    logic [16:0] h_addr [4];
    logic [3:0]  h_fg [4];
    logic [3:0]  h_bg [4];
    bit          h_v [4];
    for (int j = 0; j < 4; j++) h_v[j] = 1'b0;
    for (int k = 0; k < 32 * 88 + 3; k++) begin
      @(negedge clk);
      for (int j = 3; j > 0; j--) begin
        h_addr[j] = h_addr[j-1]; h_fg[j] = h_fg[j-1];
        h_bg[j] = h_bg[j-1]; h_v[j] = h_v[j-1];
      end
      h_v[0] = 1'b0;
      if (k < 32 * 88) begin
        int c = k % 88;
        int r = k / 88;
        int lin = r * 80 + c;
        logic [16:0] a = exp_addr(c, r);
        bit inr = (c < 80) && (r < (tall_rows ? 27 : 24));
        bit b = mem_byte(a)[7 - (lin % 8)];
        bit use_alt = inr && b && alt_now;
        col = 7'(c); row = 5'(r);
        h_addr[0] = a;
        h_fg[0] = use_alt ? alt_clr[7:4] : norm_clr[7:4];
        h_bg[0] = use_alt ? alt_clr[3:0] : norm_clr[3:0];
        h_v[0] = 1'b1;
      end
      // R1 R2: address due one edge after sampling
      if (h_v[1]) check(rd_addr == h_addr[1], "R1/R2 addr", rd_addr, h_addr[1]);
      // R3 R4 R8: colours due three edges after sampling
      if (h_v[3]) begin
        check(fg_idx == h_fg[3], "R3/R4/R8 fg", fg_idx, h_fg[3]);
        check(bg_idx == h_bg[3], "R3/R4/R8 bg", bg_idx, h_bg[3]);
      end
    end
  endtask

  task automatic phase_run(input int on, input int off, input int c_hot);
    period = 8'((on << 4) | off);
    do_reset();
    col = 7'(c_hot); row = '0;
    repeat (4) @(negedge clk);
    check(fg_idx == norm_clr[7:4], "R5 start normal", fg_idx, norm_clr[7:4]);
    for (int f = 1; f <= 90; f++) begin
      bit a;
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
      repeat (3) @(negedge clk);
      a = exp_alt_phase(f, on, off);
      // R5 R6
      check(fg_idx == (a ? alt_clr[7:4] : norm_clr[7:4]), "R5/R6 phase", fg_idx,
            a ? alt_clr[7:4] : norm_clr[7:4]);
    end
  endtask

  initial begin
    int c_hot = -1;
    norm_clr = 8'h5A; alt_clr = 8'hC3;
    tbl_page = 3'b101; tbl_blk = 5'b10110;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(rd_addr == '0, "R9 addr", rd_addr, 0);
    check(fg_idx == '0 && bg_idx == '0, "R9 colours", {fg_idx, bg_idx}, 0);
    rst = 1'b0;

    // normal phase, 24 rows
    period = 8'h1F; tall_rows = 1'b0;
    sweep(1'b0);
    // move to alternate phase (10 frame pulses)
    for (int f = 0; f < 10; f++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
    tbl_page = 3'b010; tbl_blk = 5'b01001;
    sweep(1'b1);
    tall_rows = 1'b1;
    tbl_page = 3'b111; tbl_blk = 5'b00011;
    sweep(1'b1);

    // locate a row-0 character whose attribute bit is set
    for (int c = 0; c < 80; c++)
      if (c_hot < 0 && mem_byte(exp_addr(c, 0))[7 - (c % 8)]) c_hot = c;
    check(c_hot >= 0, "R3 hot char found", c_hot, 0);
    if (c_hot < 0) c_hot = 0;

    phase_run(2, 1, c_hot);
    phase_run(1, 2, c_hot);
    phase_run(3, 0, c_hot);
    phase_run(0, 3, c_hot);
    phase_run(0, 0, c_hot);

    // R7: clearing the period mid-alternate-phase returns to normal
    period = 8'h03;
    do_reset();
    col = 7'(c_hot); row = '0;
    for (int f = 0; f < 20; f++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(fg_idx == alt_clr[7:4], "R6 alt holds", fg_idx, alt_clr[7:4]);
    period = 8'h00;
    repeat (3) @(negedge clk);
    check(fg_idx == norm_clr[7:4], "R7 zero period", fg_idx, norm_clr[7:4]);
    check(bg_idx == norm_clr[3:0], "R7 zero period bg", bg_idx, norm_clr[3:0]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule